// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits between a byte-wide receive MAC and a circular buffer in memory. The MAC presents a frame one byte per cycle, marks the final byte, and supplies error and address-class flags with it. The block stores each frame in the ring as an entry: a 32-bit word of status and length, then the payload, with the next entry starting on a 4-byte boundary. Payload bytes go to memory as they arrive. The header word is written only after the last payload byte, so the host never sees a half-built entry.

The host consumes entries and reports its progress by writing its new read offset minus 16 to a pointer input. The block compares that position with its own write offset. From this it drives a buffer-empty flag, and it refuses any frame that would run over unread data. Two sticky interrupt flags report a stored good frame and a dropped frame. The host clears each one by writing a one to its bit.

The ring holds 8 KB shifted left by a 2-bit size index (0, 1 or 2). Memory is reached through a simple word-wide write port with byte enables.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, buf_empty is 1, both interrupt flags are 0, no memory write is issued, and the first entry is placed at ring offset 0.
- R2: Payload byte k of an entry that starts at offset W is written to byte offset (W+4+k) mod ring size. Each such write enables exactly one byte lane: lane = offset bits [1:0], word = offset bits [AW-1:2].
- R3: A stored frame produces one full-word write (all four byte enables) at word W/4. Bits [31:16] hold the byte count (all bytes received, FCS included), and bits [15:0] hold the status.
- R4: Status bit 0 is 1 when in_err is all zero. Bits 5..1 copy in_err[4:0] (alignment, CRC, too long, runt, bad symbol). Bits 15..13 copy in_kind[2:0] (multicast, physical match, broadcast). Every other bit is 0.
- R5: After a stored frame of count N, the next entry starts at (W + N + 4 + 3) & ~3, mod ring size.
- R6: Payload that runs past the ring end continues at offset 0.
- R7: A host pointer write of value V sets the read offset to (V + 16) mod ring size.
- R8: buf_empty is 1 exactly when the read offset equals the write offset. Without a host pointer write, it falls only in the cycle in which a header write is presented.
- R9: Let free = (read − write) mod ring size, or the full ring size when the two are equal. A frame is stored only if round4(N+4) + 4 ≤ free. Otherwise the block writes no header, leaves the write offset unchanged, writes nothing within 4 bytes of unread data, and sets irq_rx_ovf.
- R10: irq_rx_ok is set in the cycle a stored frame with status bit 0 set has its header presented. A stored errored frame does not set it.
- R11: Writing irq_ack with irq_ack_wr clears the flags whose bits are 1 (bit 0 = receive OK, bit 1 = overflow). A set in the same cycle wins over a clear.
- R12: The header write (or the overflow flag, for a dropped frame) is presented two cycles after the cycle that carries the last byte. in_valid must be low in the cycle after in_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte present |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 5 | Error flags, valid with in_last |
| in_kind | input | 3 | Address-class flags, valid with in_last |
| host_ptr_wr | input | 1 | Host read-pointer write strobe |
| host_ptr | input | 16 | Host read offset minus 16 |
| irq_ack_wr | input | 1 | Interrupt acknowledge strobe |
| irq_ack | input | 2 | Write-one-to-clear mask |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW-2 | Memory word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| buf_empty | output | 1 | No unread entry remains |
| irq_rx_ok | output | 1 | Good frame stored |
| irq_rx_ovf | output | 1 | Frame dropped for lack of space |

## Verification
The bench sweeps every frame length from 1 to 60 over a small ring, so every start alignment and many wrap splits occur. A wrong rounding of the next offset, or a missed wrap, would leave headers and payload at the wrong place in the bench's memory image. Filling the ring without consuming it drives frames into the space check. An off-by-one there would either drop a frame that fits exactly or write payload over an unread entry, and the bench compares the unread bytes before and after the drop. It also raises an acknowledge in the same cycle as a set, so that a design that let the clear win would show a cleared flag.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  localparam int CNT_W       = 16;
  localparam int ST_OK_BIT   = 0;
  localparam int ST_ERR_LSB  = 1;
  localparam int ST_KIND_LSB = 13;

  typedef struct packed {
    logic [15:0] count;
    logic [15:0] status;
  } rrw_hdr_t;
endpackage

// File: rtl/rrw_space.sv
module rrw_space #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] rd_off,
  input  logic [AW-1:0] wr_off,
  output logic [AW:0]   free_bytes
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = rd_off - wr_off;
    if (diff == '0) free_bytes = {1'b1, {AW{1'b0}}};
    else            free_bytes = {1'b0, diff};
  end
endmodule

// File: rtl/rrw_hdr_fmt.sv
module rrw_hdr_fmt
  import rrw_pkg::*;
(
  input  logic [4:0]       err,
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] count,
  output rrw_hdr_t         hdr
);
  always_comb begin
    hdr = '0;
    hdr.count                                = count;
    hdr.status[ST_OK_BIT]                    = ~|err;
    hdr.status[ST_ERR_LSB +: 5]              = err;
    hdr.status[ST_KIND_LSB +: 3]             = kind;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rrw_pkg::*;
#(
  parameter int RING_BASE_BYTES = 8192,
  parameter int SIZE_IDX        = 0,
  parameter int HOST_PTR_BIAS   = 16,
  localparam int RING_BYTES     = RING_BASE_BYTES << SIZE_IDX,
  localparam int AW             = $clog2(RING_BYTES),
  localparam int WAW            = AW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  input  logic           in_last,
  input  logic [4:0]     in_err,
  input  logic [2:0]     in_kind,
  input  logic           host_ptr_wr,
  input  logic [15:0]    host_ptr,
  input  logic           irq_ack_wr,
  input  logic [1:0]     irq_ack,
  output logic           mem_we,
  output logic [WAW-1:0] mem_addr,
  output logic [3:0]     mem_be,
  output logic [31:0]    mem_wdata,
  output logic           buf_empty,
  output logic           irq_rx_ok,
  output logic           irq_rx_ovf
);
  logic [AW-1:0]    wr_off_q, rd_off_q, wr_off_d, rd_off_d;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             drop_q, hdr_pend_q, keep_q;
  rrw_hdr_t         hdr_q, hdr_now;
  logic [AW:0]      free_w;
  logic             fits;
  logic [AW-1:0]    byte_addr, entry_len;
  logic             set_ok, set_ovf, clr_ok, clr_ovf;

  rrw_space #(.AW(AW)) u_space (
    .rd_off     (rd_off_q),
    .wr_off     (wr_off_q),
    .free_bytes (free_w)
  );

  assign cnt_inc = cnt_q + 1'b1;

  rrw_hdr_fmt u_fmt (
    .err   (in_err),
    .kind  (in_kind),
    .count (cnt_inc),
    .hdr   (hdr_now)
  );

  // byte k may land only if the finished entry plus a 4-byte guard still fits
  assign fits      = ({1'b0, cnt_q} + (CNT_W+1)'(9)) <= {{(CNT_W-AW){1'b0}}, free_w};
  assign byte_addr = wr_off_q + AW'(4) + cnt_q[AW-1:0];
  assign entry_len = AW'((32'(hdr_q.count) + 32'd7) & ~32'd3);

  assign wr_off_d = (hdr_pend_q && keep_q) ? wr_off_q + entry_len : wr_off_q;
  assign rd_off_d = host_ptr_wr ? host_ptr[AW-1:0] + AW'(HOST_PTR_BIAS) : rd_off_q;

  assign set_ok  = hdr_pend_q && keep_q && hdr_q.status[ST_OK_BIT];
  assign set_ovf = hdr_pend_q && !keep_q;
  assign clr_ok  = irq_ack_wr && irq_ack[0];
  assign clr_ovf = irq_ack_wr && irq_ack[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_off_q   <= '0;
      rd_off_q   <= '0;
      cnt_q      <= '0;
      drop_q     <= 1'b0;
      hdr_pend_q <= 1'b0;
      keep_q     <= 1'b0;
      hdr_q      <= '0;
      buf_empty  <= 1'b1;
      irq_rx_ok  <= 1'b0;
      irq_rx_ovf <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
    end else begin
      wr_off_q   <= wr_off_d;
      rd_off_q   <= rd_off_d;
      buf_empty  <= (wr_off_d == rd_off_d);
      irq_rx_ok  <= (irq_rx_ok  & ~clr_ok)  | set_ok;
      irq_rx_ovf <= (irq_rx_ovf & ~clr_ovf) | set_ovf;
      mem_we     <= 1'b0;
      hdr_pend_q <= 1'b0;
      if (hdr_pend_q && keep_q) begin
        mem_we    <= 1'b1;
        mem_addr  <= wr_off_q[AW-1:2];
        mem_be    <= 4'hF;
        mem_wdata <= hdr_q;
      end
      if (in_valid) begin
        if (!drop_q && fits) begin
          mem_we    <= 1'b1;
          mem_addr  <= byte_addr[AW-1:2];
          mem_be    <= 4'(4'b0001 << byte_addr[1:0]);
          mem_wdata <= {4{in_data}};
        end
        if (in_last) begin
          hdr_pend_q <= 1'b1;
          hdr_q      <= hdr_now;
          keep_q     <= !drop_q && fits;
          cnt_q      <= '0;
          drop_q     <= 1'b0;
        end else begin
          cnt_q  <= cnt_inc;
          drop_q <= drop_q | !fits;
        end
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (buf_empty && !irq_rx_ok && !irq_rx_ovf && !mem_we));

  // R12
  in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> !in_valid);

  // R3
  hdr_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be == 4'hF) |-> $past(in_valid && in_last, 2));

  // R2
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be == 4'hF || $countones(mem_be) == 1));

  // R8
  empty_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(buf_empty) && !$past(host_ptr_wr)) |-> (mem_we && mem_be == 4'hF));

  // R9
  ovf_no_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_rx_ovf) |-> !(mem_we && mem_be == 4'hF));

  // R10
  ok_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_rx_ok) |-> (mem_we && mem_be == 4'hF && mem_wdata[0]));
endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;
  localparam int RB  = 256;
  localparam int MSK = RB - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic [4:0]  in_err = '0;
  logic [2:0]  in_kind = '0;
  logic        host_ptr_wr = 1'b0, irq_ack_wr = 1'b0;
  logic [15:0] host_ptr = '0;
  logic [1:0]  irq_ack = '0;
  logic        mem_we, buf_empty, irq_rx_ok, irq_rx_ovf;
  logic [5:0]  mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;

  always #2.5 clk = ~clk;

  rx_ring_writer #(.RING_BASE_BYTES(RB), .SIZE_IDX(0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_kind(in_kind), .host_ptr_wr(host_ptr_wr), .host_ptr(host_ptr),
    .irq_ack_wr(irq_ack_wr), .irq_ack(irq_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .buf_empty(buf_empty),
    .irq_rx_ok(irq_rx_ok), .irq_rx_ovf(irq_rx_ovf)
  );

  logic [7:0] bmem [RB];
  logic [7:0] snap [RB];
  initial for (int i = 0; i < RB; i++) bmem[i] = 8'h00;
  always @(posedge clk)
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) bmem[int'(mem_addr) * 4 + b] <= mem_wdata[8*b +: 8];

  int n_chk = 0, n_fail = 0;
  int W = 0, R = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 7 + k * 13 + 5) & 255);
  endfunction

  task automatic host_set(input int off);
    @(negedge clk);
    host_ptr_wr = 1'b1;
    host_ptr    = 16'((off - 16) & 16'hFFFF);
    @(negedge clk);
    host_ptr_wr = 1'b0;
    R = off & MSK;
    // R7 R8: empty follows read offset vs write offset
    check(buf_empty == (R == W), "R7 empty after pointer write", buf_empty, (R == W));
  endtask

  task automatic ack_all();
    @(negedge clk);
    irq_ack_wr = 1'b1; irq_ack = 2'b11;
    @(negedge clk);
    irq_ack_wr = 1'b0; irq_ack = 2'b00;
    check(!irq_rx_ok && !irq_rx_ovf, "R11 flags cleared", {irq_rx_ok, irq_rx_ovf}, 0);
  endtask

  task automatic send(input int len, input logic [4:0] err, input logic [2:0] kind,
                      input int seed, input bit ack_gap);
    int f, elen, bad, rel;
    bit stored, ok_before;
    logic [31:0] exp_hdr, got_hdr;
    f = (R - W) & MSK;
    if (f == 0) f = RB;
    elen   = (len + 7) & ~3;
    stored = (elen + 4) <= f;
    exp_hdr = {16'(len), kind, 7'b0, err, ~|err};
    ok_before = irq_rx_ok;
    for (int i = 0; i < RB; i++) snap[i] = bmem[i];
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(seed, k); in_last = (k == len - 1);
      in_err = err; in_kind = kind;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (ack_gap) begin irq_ack_wr = 1'b1; irq_ack = 2'b01; end
    @(negedge clk);
    irq_ack_wr = 1'b0; irq_ack = 2'b00;
    // R12: header presented two cycles after the last byte
    if (stored)
      check(mem_we && mem_be == 4'hF && int'(mem_addr) == W / 4, "R12 header timing",
            {mem_we, mem_be, mem_addr}, {1'b1, 4'hF, 6'(W / 4)});
    else begin
      check(!mem_we, "R12 no header on drop", mem_we, 0);
      check(irq_rx_ovf, "R9 overflow flag", irq_rx_ovf, 1);
    end
    if (stored) begin
      if (err == 0 || ack_gap)
        check(irq_rx_ok == 1'b1, "R10 ok flag set", irq_rx_ok, 1);
      else
        check(irq_rx_ok == ok_before, "R10 errored frame leaves ok flag", irq_rx_ok, ok_before);
      check(!buf_empty, "R8 empty clears with header", buf_empty, 0);
    end
    @(negedge clk);
    if (stored) begin
      got_hdr = {bmem[W+3], bmem[W+2], bmem[W+1], bmem[W]};
      check(got_hdr == exp_hdr, "R3 R4 header word", got_hdr, exp_hdr);
      bad = 0;
      for (int k = 0; k < len; k++)
        if (bmem[(W + 4 + k) & MSK] !== pat(seed, k)) bad++;
      // R2 R6: payload placement incl. wrap
      check(bad == 0, "R2 R6 payload bytes", bad, 0);
      W = (W + elen) & MSK;  // R5
    end else begin
      bad = 0;
      for (int p = 0; p < RB; p++) begin
        rel = (p - W) & MSK;
        if (rel >= f - 4 && bmem[p] !== snap[p]) bad++;
      end
      check(bad == 0, "R9 unread data untouched", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(buf_empty && !irq_rx_ok && !irq_rx_ovf && !mem_we, "R1 reset state",
          {buf_empty, irq_rx_ok, irq_rx_ovf, mem_we}, 4'b1000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(buf_empty, "R1 empty after reset", buf_empty, 1);

    // sweep of lengths with host keeping up; W walks all alignments and wraps (R5 R6)
    for (int len = 1; len <= 60; len++) begin
      logic [4:0] e;
      e = ((len % 7) == 0) ? 5'(1 << (len % 5)) : 5'd0;
      ack_all();
      send(len, e, 3'(len % 8), len, 1'b0);
      host_set(W);
    end

    // R11: set wins over simultaneous clear
    ack_all();
    send(20, 5'd0, 3'd2, 99, 1'b1);
    check(irq_rx_ok, "R11 set wins over clear", irq_rx_ok, 1);
    host_set(W);
    ack_all();

    // R9: fill without consuming until a frame is refused
    for (int n = 0; n < 5; n++) send(50, 5'd0, 3'd1, 200 + n, 1'b0);
    check(irq_rx_ovf && !buf_empty, "R9 ring full state", {irq_rx_ovf, buf_empty}, 2'b10);
    ack_all();
    host_set(W);
    send(8, 5'd0, 3'd4, 77, 1'b0);  // lands at the unchanged write offset
    host_set(W);
    ack_all();

    // R9 exact-fit boundary
    host_set((W + 64) & MSK);
    send(56, 5'd0, 3'd0, 31, 1'b0);
    check(!irq_rx_ovf, "R9 exact fit stored", irq_rx_ovf, 0);
    host_set((W + 60) & MSK);
    send(53, 5'd0, 3'd0, 32, 1'b0);
    check(irq_rx_ovf, "R9 four bytes short dropped", irq_rx_ovf, 1);
    host_set(W);
    check(buf_empty, "R8 empty when caught up", buf_empty, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule